// File: doc/BRIEF.md
# Successive-Approximation Converter Control Port

This block is the digital half of a 16-bit successive-approximation converter. A falling edge on the active-low convert-start input freezes the analog sample and starts a sequence of bit decisions. The block drives a trial code to the external capacitor DAC, one bit position per clock, starting at the most significant bit. On each clock it reads back a single comparator bit that says whether the trial bit stays set. When the last bit has been decided, the block latches the code into a result register and drops its busy flag. The result always belongs to the conversion that just finished; there is no pipeline delay.

The result is read from a 16-bit bus. Two pins reshape the bus. One selects straight-binary or two's-complement coding, where two's complement is the straight code with its top bit inverted. The other exchanges the two bytes, so an 8-bit host can fetch both halves over its low lane. The bus is driven only while chip-select and read are both low. A separate enable output reports that condition, and the data lines read zero while the enable is low.

A high reset level cancels a running conversion at once. A high power-down level only refuses new conversions: a conversion already under way still finishes and updates the result.

Top module: `sar_ctrl_port`

## Requirements
- R1: A falling edge on `conv_n` (high at one rising clock edge, low at the next) starts a conversion when the sequencer is idle and `pwr_dn` is low. `busy` is high from the rising edge that sees the low level.
- R2: `busy` stays high for exactly 17 clock cycles: 16 decision cycles and one latch cycle. The result register updates on the same edge where `busy` falls.
- R3: The first trial code is 0x8000. Bits are decided from MSB to LSB, and a bit stays set when `cmp_bit` is 1. With an ideal comparator (`cmp_bit` = target >= `trial_code`), the result equals the target, including 0x0000, 0x7FFF, 0x8000 and 0xFFFF.
- R4: A falling edge on `conv_n` while `busy` is high is ignored. The running conversion keeps its 17-cycle length and its result.
- R5: During a conversion the bus keeps returning the previous result.
- R6: With `byte_swap` = 0 the bus is the code as it stands. With `byte_swap` = 1, code bits 7:0 appear on `data_out[15:8]` and code bits 15:8 appear on `data_out[7:0]`.
- R7: With `twos_sel` = 0 the code is straight binary. With `twos_sel` = 1, bit 15 of the result is inverted and all other bits are unchanged. Coding is applied before any byte swap.
- R8: `data_oe` is high only while `cs_n` and `rd_n` are both low. While `data_oe` is low, `data_out` is all zeros.
- R9: `rst` high forces `busy` low, the trial code to zero and the result to zero on the next rising edge, and it aborts any running conversion. After `rst` is released, the block stays idle until a new falling edge arrives.
- R10: With `pwr_dn` high, a falling edge on `conv_n` does not start a conversion and the result is unchanged. Raising `pwr_dn` during a conversion does not shorten that conversion or change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Active-high reset; aborts any conversion |
| conv_n | input | 1 | Convert-start; falling edge samples and starts |
| pwr_dn | input | 1 | Active-high power-down; blocks new conversions |
| cmp_bit | input | 1 | Comparator decision for the current trial bit |
| trial_code | output | 16 | Trial code driven to the capacitor DAC |
| busy | output | 1 | High while a conversion is running |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| byte_swap | input | 1 | 1: exchange the high and low bytes on the bus |
| twos_sel | input | 1 | 1: two's-complement coding, 0: straight binary |
| data_out | output | 16 | Result bus, zero when not enabled |
| data_oe | output | 1 | Bus drive enable (models the high-impedance state) |

## Verification
Every cycle, the assertions check the following. Each accepted start raises `busy` and loads the MSB-only trial code. Only the latch step can lower `busy`, so stray start edges cannot end or restart a conversion. The result register changes only on the latch step. Power-down in idle keeps `busy` low, and a disabled bus stays at zero. The full 17-cycle length, the final code for boundary targets, the two byte orders combined with both codings, and the cancel-by-reset path need the bench's comparator model and its scenarios. The bench compares these against its own cycle model.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Sequencer phases: waiting, deciding bits, committing the result
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_LATCH = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_n,
  input  logic         pwr_dn,
  input  logic         cmp_bit,
  output logic         busy,
  output logic [W-1:0] trial,
  output logic [W-1:0] result
);

  localparam int             IW       = $clog2(W);
  localparam logic [W-1:0]   MSB_ONLY = {1'b1, {(W-1){1'b0}}};
  localparam logic [IW-1:0]  TOP_IDX  = IW'(W - 1);

  // Decide the bit at pos, then raise the next lower bit as the new trial
  function automatic logic [W-1:0] next_trial(input logic [W-1:0]  cur,
                                              input logic [IW-1:0] pos,
                                              input logic          keep);
    logic [W-1:0] t;
    t      = cur;
    t[pos] = keep;
    if (pos != '0) t[pos - IW'(1)] = 1'b1;
    return t;
  endfunction

  seq_state_e    state;
  logic [IW-1:0] idx;
  logic [W-1:0]  trial_q;
  logic [W-1:0]  result_q;
  logic          busy_q;
  logic          conv_q;

  // Named internal events
  logic conv_fall;
  logic start_evt;
  logic decide_evt;
  logic last_bit;
  logic latch_evt;

  assign conv_fall  = conv_q & ~conv_n;
  assign start_evt  = (state == ST_IDLE) && conv_fall && !pwr_dn;
  assign decide_evt = (state == ST_CONV);
  assign last_bit   = decide_evt && (idx == '0);
  assign latch_evt  = (state == ST_LATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q   <= 1'b1;
      state    <= ST_IDLE;
      idx      <= '0;
      trial_q  <= '0;
      result_q <= '0;
      busy_q   <= 1'b0;
    end else begin
      conv_q <= conv_n;
      case (state)
        ST_IDLE: begin
          if (start_evt) begin
            state   <= ST_CONV;
            idx     <= TOP_IDX;
            trial_q <= MSB_ONLY;
            busy_q  <= 1'b1;
          end
        end
        ST_CONV: begin
          trial_q <= next_trial(trial_q, idx, cmp_bit);
          if (last_bit) state <= ST_LATCH;
          else          idx   <= idx - IW'(1);
        end
        ST_LATCH: begin
          result_q <= trial_q;
          busy_q   <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = busy_q;
  assign trial  = trial_q;
  assign result = result_q;

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> busy);

  // R3
  first_trial_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (trial == MSB_ONLY));

  // R2
  latch_done_chk: assert property (@(posedge clk) disable iff (rst)
    latch_evt |=> !busy);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !latch_evt) |=> busy);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_evt |=> $stable(result));

  // R10
  pwrdn_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && pwr_dn) |=> !busy);

endmodule

// File: rtl/sar_outfmt.sv
module sar_outfmt #(
  parameter int W = 16
) (
  input  logic [W-1:0] result,
  input  logic         byte_swap,
  input  logic         twos_sel,
  input  logic         cs_n,
  input  logic         rd_n,
  output logic [W-1:0] data_out,
  output logic         data_oe
);

  localparam int NB = W / 8;

  // Two's complement of an offset-binary code: flip the sign position
  function automatic logic [W-1:0] recode(input logic [W-1:0] v, input logic twos);
    logic [W-1:0] r;
    r        = v;
    r[W-1]   = v[W-1] ^ twos;
    return r;
  endfunction

  logic [W-1:0] coded;
  logic [W-1:0] swapped;
  logic [W-1:0] lane_sel;

  assign coded = recode(result, twos_sel);

  // Byte-lane reversal, one lane per generate step
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign swapped[g*8 +: 8] = coded[(NB-1-g)*8 +: 8];
  end

  assign lane_sel = byte_swap ? swapped : coded;
  assign data_oe  = !cs_n && !rd_n;
  assign data_out = data_oe ? lane_sel : '0;

  // R8
  always_comb begin
    if (cs_n || rd_n) begin
      bus_quiet_chk: assert (data_out == '0);
    end
  end

endmodule

// File: rtl/sar_ctrl_port.sv
module sar_ctrl_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_n,
  input  logic         pwr_dn,
  input  logic         cmp_bit,
  output logic [W-1:0] trial_code,
  output logic         busy,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         byte_swap,
  input  logic         twos_sel,
  output logic [W-1:0] data_out,
  output logic         data_oe
);

  logic [W-1:0] result_w;

  sar_seq #(.W(W)) seq_i (
    .clk     (clk),
    .rst     (rst),
    .conv_n  (conv_n),
    .pwr_dn  (pwr_dn),
    .cmp_bit (cmp_bit),
    .busy    (busy),
    .trial   (trial_code),
    .result  (result_w)
  );

  sar_outfmt #(.W(W)) fmt_i (
    .result    (result_w),
    .byte_swap (byte_swap),
    .twos_sel  (twos_sel),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .data_out  (data_out),
    .data_oe   (data_oe)
  );

endmodule

// File: tb/sar_ctrl_port_tb.sv
`timescale 1ns/1ps
module sar_ctrl_port_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        conv_n;
  logic        pwr_dn;
  logic        cmp_bit;
  logic [15:0] trial_code;
  logic        busy;
  logic        cs_n;
  logic        rd_n;
  logic        byte_swap;
  logic        twos_sel;
  logic [15:0] data_out;
  logic        data_oe;

  logic [15:0] target;
  logic [15:0] prev;
  int          n_chk = 0;
  int          n_err = 0;
  int          cycles = 0;
  bit          run_cmp = 1'b0;

  always #2 clk = ~clk;

  // Ideal comparator: the trial bit stays when the input is at or above the trial code
  assign cmp_bit = (target >= trial_code);

  sar_ctrl_port dut_i (
    .clk(clk), .rst(rst), .conv_n(conv_n), .pwr_dn(pwr_dn), .cmp_bit(cmp_bit),
    .trial_code(trial_code), .busy(busy), .cs_n(cs_n), .rd_n(rd_n),
    .byte_swap(byte_swap), .twos_sel(twos_sel), .data_out(data_out), .data_oe(data_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Behavioural reference: counts cycles, takes the target as the ideal answer
  int          m_cnt;
  bit          m_busy;
  logic [15:0] m_res;
  bit          m_conv_prev;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_cnt <= 0; m_res <= 16'h0; m_conv_prev <= 1;
    end else begin
      m_conv_prev <= conv_n;
      if (!m_busy) begin
        if (m_conv_prev && !conv_n && !pwr_dn) begin
          m_busy <= 1; m_cnt <= 0;
        end
      end else if (m_cnt == 16) begin
        m_busy <= 0; m_res <= target;
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  function automatic logic [15:0] model_bus();
    logic [15:0] v;
    if (cs_n || rd_n) return 16'h0;
    v = m_res;
    if (twos_sel)  v = v ^ 16'h8000;
    if (byte_swap) v = (v << 8) | (v >> 8);
    return v;
  endfunction

  always @(negedge clk) begin
    if (run_cmp) begin
      chk(busy == m_busy, "R2 busy per-cycle", {31'b0, busy}, {31'b0, m_busy});
      chk(data_out == model_bus(), "R6 bus per-cycle", {16'h0, data_out}, {16'h0, model_bus()});
      chk(data_oe == (!cs_n && !rd_n), "R8 enable per-cycle", {31'b0, data_oe}, {31'b0, (!cs_n && !rd_n)});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_err++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", cycles, 50000);
      summary();
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Start a conversion; optional stray start edge or power-down during it
  task automatic convert(input logic [15:0] t, input int glitch_at, input int pd_at, output int bcnt);
    target = t;
    @(negedge clk) conv_n = 1'b0;
    @(negedge clk) conv_n = 1'b1;
    chk(busy == 1'b1, "R1 start", {31'b0, busy}, 32'd1);
    chk(trial_code == 16'h8000, "R3 first trial", {16'h0, trial_code}, 32'h8000);
    bcnt = 1;
    while (busy && bcnt < 100) begin
      conv_n = (bcnt == glitch_at) ? 1'b0 : 1'b1;
      if (bcnt == pd_at) pwr_dn = 1'b1;
      if (bcnt == 8) chk(data_out == prev, "R5 old value", {16'h0, data_out}, {16'h0, prev});
      @(negedge clk);
      if (busy) bcnt++;
    end
    conv_n = 1'b1;
    pwr_dn = 1'b0;
    prev = t;
  endtask

  initial begin
    int b;
    rst = 1; conv_n = 1; pwr_dn = 0; cs_n = 0; rd_n = 0;
    byte_swap = 0; twos_sel = 0; target = 16'h0; prev = 16'h0;
    cyc(3);
    run_cmp = 1;
    chk(busy == 0, "R9 reset busy", {31'b0, busy}, 0);
    chk(data_out == 16'h0, "R9 reset result", {16'h0, data_out}, 0);
    chk(trial_code == 16'h0, "R9 reset trial", {16'h0, trial_code}, 0);
    rst = 0;
    cyc(2);

    convert(16'h1234, 0, 0, b);
    chk(b == 17, "R2 busy length", b, 17);
    chk(data_out == 16'h1234, "R3 code", {16'h0, data_out}, 32'h1234);

    byte_swap = 1; #1;
    chk(data_out == 16'h3412, "R6 swapped", {16'h0, data_out}, 32'h3412);
    twos_sel = 1; #1;
    chk(data_out == 16'h3492, "R7 twos swapped", {16'h0, data_out}, 32'h3492);
    byte_swap = 0; #1;
    chk(data_out == 16'h9234, "R7 twos", {16'h0, data_out}, 32'h9234);
    twos_sel = 0;
    cs_n = 1; #1;
    chk(data_oe == 0 && data_out == 16'h0, "R8 cs high", {15'h0, data_oe, data_out}, 0);
    cs_n = 0; rd_n = 1; #1;
    chk(data_oe == 0 && data_out == 16'h0, "R8 rd high", {15'h0, data_oe, data_out}, 0);
    rd_n = 0; #1;
    chk(data_oe == 1, "R8 both low", {31'b0, data_oe}, 1);

    convert(16'hFFFF, 0, 0, b);
    chk(data_out == 16'hFFFF, "R3 all ones", {16'h0, data_out}, 32'hFFFF);
    convert(16'h0000, 0, 0, b);
    chk(data_out == 16'h0000, "R3 zero", {16'h0, data_out}, 0);
    convert(16'h7FFF, 0, 0, b);
    chk(data_out == 16'h7FFF, "R3 below mid", {16'h0, data_out}, 32'h7FFF);
    convert(16'h8000, 0, 0, b);
    chk(data_out == 16'h8000, "R3 mid", {16'h0, data_out}, 32'h8000);
    twos_sel = 1; #1;
    chk(data_out == 16'h0000, "R7 mid as twos", {16'h0, data_out}, 0);
    byte_swap = 1; #1;
    chk(data_out == 16'h0000, "R6 mid twos swapped", {16'h0, data_out}, 0);
    byte_swap = 0; twos_sel = 0;

    // R4: stray start edge mid-conversion
    convert(16'hABCD, 5, 0, b);
    chk(b == 17, "R4 length kept", b, 17);
    chk(data_out == 16'hABCD, "R4 result kept", {16'h0, data_out}, 32'hABCD);

    // R10: power-down blocks a start
    pwr_dn = 1;
    target = 16'h1111;
    @(negedge clk) conv_n = 0;
    @(negedge clk) conv_n = 1;
    cyc(3);
    chk(busy == 0, "R10 blocked", {31'b0, busy}, 0);
    chk(data_out == 16'hABCD, "R10 result unchanged", {16'h0, data_out}, 32'hABCD);
    pwr_dn = 0;
    cyc(2);

    // R10: power-down raised mid-conversion lets it finish
    convert(16'h2468, 0, 4, b);
    chk(b == 17, "R10 completes", b, 17);
    chk(data_out == 16'h2468, "R10 result", {16'h0, data_out}, 32'h2468);

    // R9: reset aborts a running conversion
    target = 16'h5555;
    @(negedge clk) conv_n = 0;
    @(negedge clk) conv_n = 1;
    cyc(5);
    rst = 1;
    cyc(1);
    chk(busy == 0, "R9 abort busy", {31'b0, busy}, 0);
    chk(data_out == 16'h0, "R9 abort result", {16'h0, data_out}, 0);
    chk(trial_code == 16'h0, "R9 abort trial", {16'h0, trial_code}, 0);
    rst = 0;
    cyc(3);
    chk(busy == 0, "R9 stays idle", {31'b0, busy}, 0);
    prev = 16'h0;

    convert(16'h5555, 0, 0, b);
    chk(b == 17, "R1 after reset", b, 17);
    chk(data_out == 16'h5555, "R1 result after reset", {16'h0, data_out}, 32'h5555);

    cyc(2);
    summary();
    $finish;
  end

endmodule